// File: doc/BRIEF.md
# Dispatch Stage Stall and Squash Controller

This block governs the flow of instruction groups through one dispatch stage of an out-of-order pipeline. Each cycle the upstream rename stage may offer a group of up to N opaque instructions. The controller forwards as many as the downstream issue queue can accept, as dispatch strobes with their payload slots. It also tells the upstream stage to hold off when the group cannot be accepted. Groups that cannot be forwarded are kept in a small skid buffer, so nothing is lost, and they are replayed later.

The stage runs a state machine with the states Idle, Running, Blocked, Unblocking and Squashing. A stall from commit or a full issue queue blocks the stage. Once the stall has gone and the queue has room, the stage drains the skid buffer at one group per cycle. A squash from commit, in either of its two forms, empties the buffer and holds the stage quiet until both squash indications have dropped. The count of free issue-queue entries is passed back upstream every cycle, one cycle late.

Top module: `dispatch_guard`

## Requirements
- R1: During and after reset the state output reads Idle (encoding 0), and `stall_up`, `disp_en`, `free_up` and `ovf_err` are all zero. Idle behaves as Running and moves to Running (encoding 1) when nothing else applies. The other encodings are Blocked 2, Unblocking 3 and Squashing 4.
- R2: `free_up` equals the value that `iq_free` had in the previous cycle, in every state.
- R3: In Running with no squash and no commit stall, the group size is k = min(c, `iq_free`), where c is `in_cnt` clamped to N when `in_valid` is high and 0 otherwise. `disp_en` bits 0..k-1 are set, and `disp_data` slot i (bits i*W upward) carries input slot i for each enabled slot. Disabled slots read zero.
- R4: In Running, if `iq_free` is less than c, the remaining c-k instructions are pushed as one skid entry whose slot 0 is the first instruction not dispatched. `stall_up` is high in that cycle and the next state is Blocked.
- R5: In Running, a commit stall (without squash) dispatches nothing, pushes the incoming group if c>0, raises `stall_up` and moves to Blocked.
- R6: In Blocked, `stall_up` is high every cycle and each incoming group with c>0 is pushed. The stage moves to Unblocking when the commit stall is low and `iq_free` is nonzero.
- R7: In Unblocking, `stall_up` is high. The head entry is dispatched as in R3. If it fits, it is popped, and the stage returns to Running when the buffer is then empty. If only part of it fits, the head keeps the remainder and the stage moves to Blocked. A commit stall moves the stage to Blocked without dispatch. Incoming groups are pushed, and the stage stays in Unblocking while the buffer is not empty.
- R8: A squash or reorder-buffer squash seen in Idle, Running, Blocked or Unblocking moves the stage to Squashing. It takes priority over a commit stall in the same cycle, dispatches nothing, pushes nothing and empties the skid buffer.
- R9: In Squashing, nothing is dispatched, `stall_up` is low and incoming groups are dropped. The stage leaves for Running in the first cycle in which both squash indications are low.
- R10: The skid buffer holds D entries. A push into a full buffer with no pop in the same cycle drops the group and sets `ovf_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group is offered by rename |
| in_cnt | input | $clog2(N+1) | Instructions in the offered group (clamped to N) |
| in_data | input | N*W | Opaque payload, slot i at bits i*W upward |
| iq_free | input | $clog2(QD+1) | Free issue-queue entries this cycle |
| cmt_stall | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Squash from commit |
| rob_squash | input | 1 | Reorder buffer is squashing |
| stall_up | output | 1 | Stall to the rename stage |
| disp_en | output | N | Per-slot dispatch strobes |
| disp_data | output | N*W | Dispatched payload slots |
| free_up | output | $clog2(QD+1) | Registered free-entry count to rename |
| state_o | output | 3 | Stage state encoding |
| ovf_err | output | 1 | Sticky skid overflow flag |

## Verification
The bench targets partial dispatch with the split point at every position, including zero free entries. A slicer that shifted the remainder wrongly would replay duplicated or missing instructions. It targets a squash arriving together with a commit stall, and a squash in Unblocking. A design that let the stall win would keep stale groups in the buffer and dispatch them after the squash. It fills the buffer under a long commit stall. A push-when-full that wrapped the write pointer would overwrite the oldest group instead of flagging overflow. A push and a pop in the same cycle on a full buffer must not be flagged at all.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } dsq_state_e;

  // number of slots that can leave this cycle
  function automatic int take_of(input int want, input int room);
    return (want < room) ? want : room;
  endfunction

  // clamp an offered group size to the slot count
  function automatic int clamp_of(input int cnt, input int slots);
    return (cnt > slots) ? slots : cnt;
  endfunction
endpackage

// File: rtl/dsq_slicer.sv
module dsq_slicer #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int CW = 3,
  parameter int FW = 5
) (
  input  logic [CW-1:0]  cnt_i,
  input  logic [N*W-1:0] data_i,
  input  logic [FW-1:0]  free_i,
  output logic [N-1:0]   en_o,
  output logic [CW-1:0]  rem_cnt_o,
  output logic [N*W-1:0] rem_data_o
);
  import dsq_pkg::*;

  logic [CW-1:0] take;

  assign take       = CW'(take_of(int'(cnt_i), int'(free_i)));
  assign rem_cnt_o  = cnt_i - take;
  assign rem_data_o = data_i >> (int'(take) * W);

  always_comb begin
    for (int i = 0; i < N; i++) en_o[i] = (i < int'(take));
  end
endmodule

// File: rtl/dsq_skid.sv
module dsq_skid #(
  parameter int DEPTH = 4,
  parameter int EW    = 35,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic [EW-1:0]   push_d_i,
  input  logic            pop_i,
  input  logic            hwr_i,
  input  logic [EW-1:0]   hwr_d_i,
  output logic [EW-1:0]   head_o,
  output logic            empty_o,
  output logic            full_o,
  output logic [CNTW-1:0] cnt_o,
  output logic            ovf_o
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_o == '0);
  assign full_o  = (int'(cnt_o) == DEPTH);
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full_o || pop_ok);
  assign ovf_o   = push_i && !push_ok;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
      cnt_o <= cnt_o + CNTW'(push_ok) - CNTW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr_i) mem[wr_ptr] <= push_d_i;
    if (hwr_i && !clr_i)   mem[rd_ptr] <= hwr_d_i;
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_o) <= DEPTH);
  p_full_push_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (int'(cnt_o) == DEPTH || $past(clr_i)));
  p_head_write_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hwr_i |-> !empty_o);
endmodule

// File: rtl/dispatch_guard.sv
module dispatch_guard #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int D  = 4,
  parameter int QD = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [$clog2(N+1)-1:0]   in_cnt,
  input  logic [N*W-1:0]           in_data,
  input  logic [$clog2(QD+1)-1:0]  iq_free,
  input  logic                     cmt_stall,
  input  logic                     cmt_squash,
  input  logic                     rob_squash,
  output logic                     stall_up,
  output logic [N-1:0]             disp_en,
  output logic [N*W-1:0]           disp_data,
  output logic [$clog2(QD+1)-1:0]  free_up,
  output logic [2:0]               state_o,
  output logic                     ovf_err
);
  import dsq_pkg::*;

  localparam int CW   = $clog2(N + 1);
  localparam int FW   = $clog2(QD + 1);
  localparam int EW   = CW + N * W;
  localparam int CNTW = $clog2(D + 1);

  dsq_state_e state, nxt;

  logic            sq_in, has_in, use_head, go;
  logic [CW-1:0]   grp_cnt, src_cnt, head_cnt, rem_cnt;
  logic [N*W-1:0]  src_data, head_data, rem_data;
  logic [N-1:0]    sl_en;
  logic            push, pop, hwr, clr;
  logic [EW-1:0]   push_d, head;
  logic            f_empty, f_full, f_ovf;
  logic [CNTW-1:0] f_cnt;

  assign sq_in   = cmt_squash || rob_squash;
  assign grp_cnt = in_valid ? CW'(clamp_of(int'(in_cnt), N)) : '0;
  assign has_in  = (grp_cnt != '0);

  assign head_cnt  = head[EW-1 -: CW];
  assign head_data = head[N*W-1:0];
  assign use_head  = (state == ST_UNB) && !f_empty;
  assign src_cnt   = use_head ? head_cnt : grp_cnt;
  assign src_data  = use_head ? head_data : in_data;

  dsq_slicer #(.N(N), .W(W), .CW(CW), .FW(FW)) u_slicer (
    .cnt_i(src_cnt), .data_i(src_data), .free_i(iq_free),
    .en_o(sl_en), .rem_cnt_o(rem_cnt), .rem_data_o(rem_data)
  );

  dsq_skid #(.DEPTH(D), .EW(EW)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .push_i(push), .push_d_i(push_d), .pop_i(pop),
    .hwr_i(hwr), .hwr_d_i({rem_cnt, rem_data}),
    .head_o(head), .empty_o(f_empty), .full_o(f_full),
    .cnt_o(f_cnt), .ovf_o(f_ovf)
  );

  always_comb begin
    nxt = state; stall_up = 1'b0; go = 1'b0;
    push = 1'b0; push_d = {grp_cnt, in_data};
    pop = 1'b0; hwr = 1'b0; clr = 1'b0;
    unique case (state)
      ST_IDLE, ST_RUN: begin
        if (sq_in) begin
          nxt = ST_SQ; clr = 1'b1;
        end else if (cmt_stall) begin
          stall_up = 1'b1; push = has_in; nxt = ST_BLK;
        end else begin
          go = 1'b1; nxt = ST_RUN;
          if (rem_cnt != '0) begin
            push = 1'b1; push_d = {rem_cnt, rem_data};
            stall_up = 1'b1; nxt = ST_BLK;
          end
        end
      end
      ST_BLK: begin
        stall_up = 1'b1;
        if (sq_in) begin
          nxt = ST_SQ; clr = 1'b1;
        end else begin
          push = has_in;
          if (!cmt_stall && iq_free != '0) nxt = ST_UNB;
        end
      end
      ST_UNB: begin
        stall_up = 1'b1;
        if (sq_in) begin
          nxt = ST_SQ; clr = 1'b1;
        end else if (cmt_stall) begin
          push = has_in; nxt = ST_BLK;
        end else if (f_empty) begin
          push = has_in; nxt = has_in ? ST_UNB : ST_RUN;
        end else begin
          go = 1'b1; push = has_in;
          if (rem_cnt != '0) begin
            hwr = 1'b1; nxt = ST_BLK;
          end else begin
            pop = 1'b1;
            nxt = (int'(f_cnt) == 1 && !has_in) ? ST_RUN : ST_UNB;
          end
        end
      end
      ST_SQ: if (!sq_in) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  assign disp_en = go ? sl_en : '0;
  for (genvar gi = 0; gi < N; gi++) begin : g_slot
    assign disp_data[gi*W +: W] = disp_en[gi] ? src_data[gi*W +: W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      free_up <= '0;
      ovf_err <= 1'b0;
    end else begin
      state   <= nxt;
      free_up <= iq_free;
      ovf_err <= ovf_err || f_ovf;
    end
  end

  assign state_o = state;

  p_free_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> free_up == $past(iq_free));
  p_disp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_en) <= int'(iq_free));
  p_cstall_nodisp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cmt_stall && !sq_in) |-> (disp_en == '0 && stall_up));
  p_blk_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_BLK |-> stall_up);
  p_squash_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_in && state != ST_SQ) |=> (state == ST_SQ && f_empty));
  p_sq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SQ |-> (disp_en == '0 && !stall_up));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

// File: tb/dispatch_guard_bench.sv
module dispatch_guard_bench;
  localparam int N = 4, W = 8, D = 4, QD = 16;
  localparam int CW = $clog2(N + 1), FW = $clog2(QD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, cmt_stall = 1'b0, cmt_squash = 1'b0, rob_squash = 1'b0;
  logic [CW-1:0] in_cnt = '0;
  logic [N*W-1:0] in_data = '0;
  logic [FW-1:0] iq_free = '0;
  logic stall_up, ovf_err;
  logic [N-1:0] disp_en;
  logic [N*W-1:0] disp_data;
  logic [FW-1:0] free_up;
  logic [2:0] state_o;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dispatch_guard #(.N(N), .W(W), .D(D), .QD(QD)) u_dispatch_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cnt(in_cnt),
    .in_data(in_data), .iq_free(iq_free), .cmt_stall(cmt_stall),
    .cmt_squash(cmt_squash), .rob_squash(rob_squash), .stall_up(stall_up),
    .disp_en(disp_en), .disp_data(disp_data), .free_up(free_up),
    .state_o(state_o), .ovf_err(ovf_err)
  );

  // reference model state
  typedef struct { int c; logic [N*W-1:0] d; } grp_t;
  grp_t mq[$];
  int m_st = 0;
  int m_free = 0;
  bit m_ovf = 0;
  logic [N-1:0] e_en;
  logic [N*W-1:0] e_data;
  bit e_stall;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] slots_of(input logic [N*W-1:0] d, input int k);
    logic [N*W-1:0] r = '0;
    for (int i = 0; i < k; i++) r[i*W +: W] = d[i*W +: W];
    return r;
  endfunction

  function automatic logic [N-1:0] mask_of(input int k);
    logic [N-1:0] r = '0;
    for (int i = 0; i < k; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic mpush(input int c, input logic [N*W-1:0] d);
    grp_t g;
    if (c == 0) return;
    if (mq.size() >= D) begin m_ovf = 1; return; end
    g.c = c; g.d = d; mq.push_back(g);
  endtask

  task automatic emit(input logic [N*W-1:0] d, input int k);
    e_en = mask_of(k); e_data = slots_of(d, k);
  endtask

  task automatic model_step();
    bit sq = cmt_squash || rob_squash;
    int g = in_valid ? ((int'(in_cnt) > N) ? N : int'(in_cnt)) : 0;
    int fr = int'(iq_free);
    e_en = '0; e_data = '0; e_stall = 0;
    if (m_st <= 1) begin
      if (sq) begin e_tag = "R8"; m_st = 4; mq.delete(); end
      else if (cmt_stall) begin e_tag = "R5"; mpush(g, in_data); e_stall = 1; m_st = 2; end
      else begin
        int k = (g < fr) ? g : fr;
        emit(in_data, k);
        if (k < g) begin e_tag = "R4"; mpush(g - k, in_data >> (k * W)); e_stall = 1; m_st = 2; end
        else begin e_tag = "R3"; m_st = 1; end
      end
    end else if (m_st == 2) begin
      e_stall = 1;
      if (sq) begin e_tag = "R8"; m_st = 4; mq.delete(); end
      else begin e_tag = "R6"; mpush(g, in_data); if (!cmt_stall && fr > 0) m_st = 3; end
    end else if (m_st == 3) begin
      e_stall = 1; e_tag = "R7";
      if (sq) begin e_tag = "R8"; m_st = 4; mq.delete(); end
      else if (cmt_stall) begin mpush(g, in_data); m_st = 2; end
      else if (mq.size() == 0) begin mpush(g, in_data); m_st = (g != 0) ? 3 : 1; end
      else begin
        grp_t h = mq[0];
        int k = (h.c < fr) ? h.c : fr;
        emit(h.d, k);
        if (k < h.c) begin
          mq[0].c = h.c - k; mq[0].d = h.d >> (k * W); m_st = 2;
          mpush(g, in_data);
        end else begin
          void'(mq.pop_front());
          mpush(g, in_data);
          m_st = (mq.size() == 0) ? 1 : 3;
        end
      end
    end else begin
      e_tag = "R9";
      if (!sq) m_st = 1;
    end
  endtask

  task automatic step(input bit v, input int c, input logic [N*W-1:0] d, input int f,
                      input bit cs, input bit sq, input bit rs);
    @(negedge clk);
    in_valid = v; in_cnt = CW'(c); in_data = d; iq_free = FW'(f);
    cmt_stall = cs; cmt_squash = sq; rob_squash = rs;
    #1;
    chk(int'(state_o) == m_st, "state R1/R6/R7/R8/R9", 64'(state_o), 64'(m_st));
    chk(int'(free_up) == m_free, "free_up R2", 64'(free_up), 64'(m_free));
    chk(ovf_err == m_ovf, "ovf_err R10", 64'(ovf_err), 64'(m_ovf));
    model_step();
    m_free = f;
    chk(disp_en == e_en, {"disp_en ", e_tag}, 64'(disp_en), 64'(e_en));
    chk(disp_data == e_data, {"disp_data ", e_tag}, 64'(disp_data), 64'(e_data));
    chk(stall_up == e_stall, {"stall_up ", e_tag}, 64'(stall_up), 64'(e_stall));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset values
    repeat (3) begin
      @(negedge clk); #1;
      chk(state_o == 3'd0, "reset state R1", 64'(state_o), 0);
      chk(!stall_up && disp_en == '0, "reset outputs R1", 64'({stall_up, disp_en}), 0);
      chk(free_up == '0 && !ovf_err, "reset free/ovf R1", 64'({free_up, ovf_err}), 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // directed corner cases
    step(1, 3, 32'hA1A2A3A4, 10, 0, 0, 0);  // R1 idle dispatches, R3
    step(1, 6, 32'h11223344, 9, 0, 0, 0);   // clamp to N, R3
    step(1, 4, 32'hB1B2B3B4, 1, 0, 0, 0);   // R4 partial split at 1
    step(1, 2, 32'h0000C1C2, 0, 1, 0, 0);   // R6 push while blocked
    step(0, 0, 32'h0, 5, 0, 0, 0);          // R6 -> unblocking
    step(0, 0, 32'h0, 2, 0, 0, 0);          // R7 partial head
    step(0, 0, 32'h0, 4, 0, 0, 0);          // R6 -> unblocking
    step(0, 0, 32'h0, 4, 0, 0, 0);          // R7 pop
    step(0, 0, 32'h0, 4, 0, 0, 0);          // R7 pop last -> running
    step(1, 4, 32'hD1D2D3D4, 0, 0, 0, 0);   // R4 split at 0
    step(1, 2, 32'h0000E1E2, 4, 1, 1, 0);   // R8 squash beats stall
    step(1, 2, 32'h0000F1F2, 4, 0, 0, 1);   // R9 holds on rob squash
    step(1, 2, 32'h0000F3F4, 4, 0, 0, 0);   // R9 release, input dropped
    step(1, 3, 32'h00515253, 8, 1, 0, 0);   // R5 stall in running
    for (int i = 0; i < 6; i++) step(1, 2, $urandom, 3, 1, 0, 0); // R10 overflow
    step(0, 0, 32'h0, 0, 0, 1, 0);          // R8 squash from blocked
    step(0, 0, 32'h0, 0, 0, 0, 0);

    // constrained random phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 1500; n++) begin
        int sp = (ph == 1) ? 40 : 12;
        int fmax = (ph == 2) ? 2 : QD;
        bit v = ($urandom_range(0, 99) < 75);
        bit cs = ($urandom_range(0, 99) < sp);
        bit sq = ($urandom_range(0, 99) < ((ph == 3) ? 10 : 3));
        bit rs = ($urandom_range(0, 99) < 2);
        step(v, $urandom_range(0, 6), $urandom, $urandom_range(0, fmax), cs, sq, rs);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule